// File: doc/BRIEF.md
# Stereo Tremolo Gain Stage

This block applies a time-varying gain to a stereo audio stream. On every sample strobe it takes one signed left sample, one signed right sample and an unsigned gain word, and returns both channels multiplied by that gain. The result keeps the upper half of each product, so the full-scale gain is just under unity. The gain word comes from a slow oscillator outside the block. Because the gain is never negative, the input polarity is never flipped, and the effect is a rise and fall in loudness rather than a ring-modulation effect.

A mode flag chooses how the right channel follows the left. In anti-phase mode the right channel is scaled by the bitwise complement of the gain, so one side gets louder while the other gets quieter and the sound sweeps between the speakers. In in-phase mode both channels use the same gain. An active-low pushbutton flips the mode once per press. The button is looked at only on sample strobes, and a held button cannot cause a second flip until a strobe has seen it released.

Top module: `trem_stereo_gain`

## Requirements
- R1: Each channel output equals floor(sample * gain / 2^16), where sample is a signed 16-bit value and gain is an unsigned 16-bit value. The output is the bits [31:16] of the exact product, with no saturation.
- R2: A nonzero output always has the same sign as its input sample. An input of zero, or a gain of zero, gives zero.
- R3: When `anti_phase` is 0, the right channel is scaled by the same gain as the left.
- R4: When `anti_phase` is 1, the right channel is scaled by the bitwise complement of the gain. So a gain of 0x0000 scales the right channel by 0xFFFF, and a gain of 0xFFFF scales it by 0x0000.
- R5: Outputs are registered. `out_valid` is high for exactly the one cycle after a clock edge at which `in_strobe` was high. Both sample outputs hold their values until the next strobe.
- R6: After a synchronous reset, `anti_phase` is 1, both outputs are 0 and `out_valid` is 0.
- R7: The first strobe that sees `btn_n` at 0, after the button was last seen released, inverts `anti_phase` from the next cycle on. The sample taken on that same strobe still uses the mode that was in force before it.
- R8: Further strobes that see `btn_n` still at 0 do not change the mode. Once a strobe sees `btn_n` at 1, the next strobe that sees it at 0 inverts the mode again.
- R9: Changes on `btn_n` between strobes have no effect. A press and release that no strobe sees leaves `anti_phase` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_strobe | input | 1 | Sample strobe, one cycle per audio sample |
| in_left | input | 16 | Signed left sample |
| in_right | input | 16 | Signed right sample |
| gain | input | 16 | Unsigned modulation gain |
| btn_n | input | 1 | Active-low mode pushbutton |
| out_left | output | 16 | Scaled left sample |
| out_right | output | 16 | Scaled right sample |
| out_valid | output | 1 | High one cycle after a strobe |
| anti_phase | output | 1 | 1 when the right gain is mirrored |

## Verification
On every cycle, the assertions check four things. Polarity is preserved on each channel. Outputs hold steady between strobes. The mode changes only on a strobe that sees the button pressed. The mode never changes while the press latch is set and the button is still pressed. The exact arithmetic value of each product, and which gain the right channel picked in each mode, can only be shown by the bench. It sweeps extreme and mid-range samples against extreme and mid-range gains in both modes. The bench also has to show the press sequences: a held press, a press and release between strobes, and which mode the toggling sample used.

// File: rtl/trem_pkg.sv
package trem_pkg;
  localparam int NUM_CH  = 2;
  localparam int CH_LEFT  = 0;
  localparam int CH_RIGHT = 1;
endpackage

// File: rtl/trem_mode_ctrl.sv
module trem_mode_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  input  logic btn_n,
  output logic anti_phase
);
  logic press_held;
  logic toggle;

  assign toggle = strobe && !btn_n && !press_held;

  always_ff @(posedge clk) begin
    if (rst) begin
      anti_phase <= 1'b1;
      press_held <= 1'b0;
    end else begin
      if (toggle) anti_phase <= ~anti_phase;
      if (strobe) press_held <= ~btn_n;
    end
  end

  // R7 / R9: mode changes only when a strobe saw the button pressed
  assert_mode_on_press_R7: assert property (@(posedge clk) disable iff (rst)
    (anti_phase != $past(anti_phase)) |-> ($past(strobe) && !$past(btn_n)));

  // R8: a latched press with the button still down never toggles
  assert_no_retoggle_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(press_held) && !$past(btn_n)) |-> (anti_phase == $past(anti_phase)));
endmodule

// File: rtl/trem_scale.sv
module trem_scale #(
  parameter int DATA_W = 16,
  parameter int GAIN_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     en,
  input  logic signed [DATA_W-1:0] sample,
  input  logic        [GAIN_W-1:0] gain,
  output logic signed [DATA_W-1:0] result
);
  localparam int PROD_W = DATA_W + GAIN_W + 1;

  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] shifted;

  always_comb begin
    prod    = $signed(sample) * $signed({1'b0, gain});
    shifted = prod >>> GAIN_W;
  end

  always_ff @(posedge clk) begin
    if (rst) result <= '0;
    else if (en) result <= DATA_W'(shifted);
  end

  // R2: polarity of the sample is never inverted
  assert_sign_kept_R2: assert property (@(posedge clk) disable iff (rst)
    $past(en) |-> ((result == '0) || (result[DATA_W-1] == $past(sample[DATA_W-1]))));

  // R5: result holds between strobes
  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !$past(en) |-> $stable(result));
endmodule

// File: rtl/trem_stereo_gain.sv
module trem_stereo_gain #(
  parameter int DATA_W = 16,
  parameter int GAIN_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_strobe,
  input  logic signed [DATA_W-1:0] in_left,
  input  logic signed [DATA_W-1:0] in_right,
  input  logic        [GAIN_W-1:0] gain,
  input  logic                     btn_n,
  output logic signed [DATA_W-1:0] out_left,
  output logic signed [DATA_W-1:0] out_right,
  output logic                     out_valid,
  output logic                     anti_phase
);
  import trem_pkg::*;

  logic signed [DATA_W-1:0] ch_in  [NUM_CH];
  logic signed [DATA_W-1:0] ch_out [NUM_CH];
  logic        [GAIN_W-1:0] ch_gain[NUM_CH];

  trem_mode_ctrl u_mode (
    .clk       (clk),
    .rst       (rst),
    .strobe    (in_strobe),
    .btn_n     (btn_n),
    .anti_phase(anti_phase)
  );

  always_comb begin
    ch_in[CH_LEFT]    = in_left;
    ch_in[CH_RIGHT]   = in_right;
    ch_gain[CH_LEFT]  = gain;
    ch_gain[CH_RIGHT] = anti_phase ? ~gain : gain;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    trem_scale #(.DATA_W(DATA_W), .GAIN_W(GAIN_W)) u_scale (
      .clk   (clk),
      .rst   (rst),
      .en    (in_strobe),
      .sample(ch_in[c]),
      .gain  (ch_gain[c]),
      .result(ch_out[c])
    );
  end

  assign out_left  = ch_out[CH_LEFT];
  assign out_right = ch_out[CH_RIGHT];

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= in_strobe;
  end
endmodule

// File: tb/trem_stereo_gain_bench.sv
module trem_stereo_gain_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_strobe = 1'b0;
  logic signed [15:0] in_left = '0, in_right = '0;
  logic [15:0] gain = '0;
  logic btn_n = 1'b1;
  logic signed [15:0] out_left, out_right;
  logic out_valid, anti_phase;

  int total = 0, bad = 0;
  bit exp_mode = 1'b1;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trem_stereo_gain u_trem_stereo_gain (
    .clk(clk), .rst(rst), .in_strobe(in_strobe), .in_left(in_left),
    .in_right(in_right), .gain(gain), .btn_n(btn_n), .out_left(out_left),
    .out_right(out_right), .out_valid(out_valid), .anti_phase(anti_phase)
  );

  function automatic logic signed [15:0] ref_mul(input int s, input int g);
    longint p;
    p = longint'(s) * longint'(g);
    return 16'(p >>> 16);
  endfunction

  function automatic int pick_sample(input int i);
    case (i)
      0: return -32768; 1: return -32767; 2: return -1;    3: return 0;
      4: return 1;      5: return 32767;  6: return -12345; default: return 20000;
    endcase
  endfunction

  function automatic int pick_gain(input int i);
    case (i)
      0: return 0;     1: return 1;     2: return 32767; 3: return 32768;
      4: return 65534; 5: return 65535; 6: return 4660;  default: return 50000;
    endcase
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one strobe; returns after the capture edge, at a negedge
  task automatic do_sample(input int sl, input int sr, input int g, input bit b);
    int gr;
    bit used_mode;
    used_mode = exp_mode;
    in_left = 16'(sl); in_right = 16'(sr); gain = 16'(g); btn_n = b;
    in_strobe = 1'b1;
    @(negedge clk);
    in_strobe = 1'b0;
    gr = used_mode ? (g ^ 65535) : g;
    check("R1 left", out_left, ref_mul(sl, g));
    check(used_mode ? "R4 right anti" : "R3 right same", out_right, ref_mul(sr, gr));
    check("R5 valid", out_valid, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R6 mode", anti_phase, 1);
    check("R6 left", out_left, 0);
    check("R6 right", out_right, 0);
    check("R6 valid", out_valid, 0);

    // R1/R4 sweep in anti-phase mode
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        do_sample(pick_sample(i), pick_sample(7 - i), pick_gain(j), 1'b1);

    // R5: hold after valid
    @(negedge clk);
    check("R5 valid low", out_valid, 0);
    check("R5 hold left", out_left, ref_mul(pick_sample(7), pick_gain(7)));

    // R7: press; that sample still uses anti-phase
    do_sample(1000, 1000, 0, 1'b0);
    exp_mode = 1'b0;
    check("R7 toggled", anti_phase, 0);
    // R8: held press does not toggle
    do_sample(-500, 700, 40000, 1'b0);
    do_sample(300, -300, 100, 1'b0);
    check("R8 held", anti_phase, 0);
    do_sample(5, 5, 65535, 1'b1);
    check("R8 release", anti_phase, 0);

    // R1/R3 sweep in in-phase mode
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        do_sample(pick_sample(i), pick_sample(7 - i), pick_gain(j), 1'b1);

    // R9: press between strobes
    btn_n = 1'b0;
    repeat (4) @(negedge clk);
    btn_n = 1'b1;
    @(negedge clk);
    check("R9 unseen press", anti_phase, 0);
    do_sample(123, -123, 30000, 1'b1);
    check("R9 after strobe", anti_phase, 0);

    // R8: new press after release toggles back
    do_sample(-2000, -2000, 60000, 1'b0);
    exp_mode = 1'b1;
    check("R8 second press", anti_phase, 1);
    do_sample(-2000, 2000, 0, 1'b1);
    check("R2 zero gain", out_left, 0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule